// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry half of taking a trap or interrupt on a 64-bit core with a machine state register (MSR). An execute stage raises a request together with the address of the next instruction, the current MSR and the handler vector chosen elsewhere. The block captures all three in the accepting cycle. It then saves the return context through one shared special-register write port across two consecutive cycles: first the resume address into SRR0, then the captured MSR into SRR1.

In the second save cycle the block also publishes the new MSR with a write strobe. In the new MSR, the 64-bit mode and little-endian bits are set, and the interrupt enable, problem state, both relocation bits and the recoverable bit are cleared. In the same cycle it sends a one-cycle fetch redirect to the handler vector. A busy output covers both save cycles, and any request seen while busy is dropped.

Top module: `excEntrySeq`

## Requirements
- R1: Reset puts the block in idle with `busy`, `sprWe`, `msrWe` and `redirect` all low.
- R2: A request seen at a clock edge while idle is accepted. In the next cycle `sprWe` is 1, `sprNum` equals `SRR0_NUM` (default 26) and `sprData` equals `nextPc` as sampled at the accepting edge.
- R3: In the cycle directly after the SRR0 write, `sprWe` is 1, `sprNum` equals `SRR1_NUM` (default 27) and `sprData` equals `msrIn` as sampled at the accepting edge.
- R4: `sprWe` is high only in those two save cycles and low in every other cycle.
- R5: In the SRR1 cycle `msrWe` is 1 and `msrNext` is the captured MSR with bits 63 and 0 set to 1, bits 15, 14, 5, 4 and 1 cleared to 0, and every other bit unchanged (LSB-0 numbering). `msrWe` is low in all other cycles.
- R6: `redirect` is a one-cycle pulse in the SRR1 cycle, with `redirectPc` equal to `vecAddr` as sampled at the accepting edge.
- R7: `busy` is high in exactly the two save cycles and low otherwise.
- R8: Changes on `nextPc`, `msrIn` and `vecAddr` after the accepting edge do not alter the values written or redirected.
- R9: A request present while `busy` is high is ignored. A request present in the first idle cycle after the redirect is accepted as a new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapReq | input | 1 | Exception entry request |
| nextPc | input | 64 | Address where execution resumes |
| msrIn | input | 64 | Current MSR |
| vecAddr | input | 64 | Handler vector address |
| busy | output | 1 | Entry sequence in progress |
| sprWe | output | 1 | Special-register write enable |
| sprNum | output | 10 | Special-register number (SRR0 or SRR1) |
| sprData | output | 64 | Special-register write data |
| msrWe | output | 1 | MSR update strobe |
| msrNext | output | 64 | New MSR value |
| redirect | output | 1 | Fetch redirect pulse |
| redirectPc | output | 64 | Fetch redirect address |

## Verification
Counting from the edge that accepts a request, the SRR0 write appears one cycle later, and the SRR1 write, MSR update and redirect appear two cycles later. `busy` covers both of those cycles and drops in the third. The bench keeps a behavioural model that advances on the same edges as the design and compares every output on the falling edge, so each result is checked in exactly the cycle it is due. Inputs are changed while the block is busy, and a request is held high over the busy window, to show that captured values stay fixed and that overlapping requests are dropped.

// File: rtl/excEntryPkg.sv
package excEntryPkg;
  localparam int XLEN = 64;

  localparam int MSR_SF = 63;
  localparam int MSR_EE = 15;
  localparam int MSR_PR = 14;
  localparam int MSR_IR = 5;
  localparam int MSR_DR = 4;
  localparam int MSR_RI = 1;
  localparam int MSR_LE = 0;

  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_SAVE_PC   = 2'd1,
    ST_SAVE_MSR  = 2'd2
  } entryState_e;

  typedef struct packed {
    logic capture;
    logic savePc;
    logic saveMsr;
  } entryStrobes_t;

  function automatic logic [XLEN-1:0] setMask();
    logic [XLEN-1:0] m;
    m = '0;
    m[MSR_SF] = 1'b1;
    m[MSR_LE] = 1'b1;
    return m;
  endfunction

  function automatic logic [XLEN-1:0] clearMask();
    logic [XLEN-1:0] m;
    m = '0;
    m[MSR_EE] = 1'b1;
    m[MSR_PR] = 1'b1;
    m[MSR_IR] = 1'b1;
    m[MSR_DR] = 1'b1;
    m[MSR_RI] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/excEntryCtrl.sv
module excEntryCtrl
  import excEntryPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          trapReq,
  output entryStrobes_t strobes,
  output logic          busy
);
  entryState_e state;
  entryState_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (trapReq) stateNext = ST_SAVE_PC;
      ST_SAVE_PC:  stateNext = ST_SAVE_MSR;
      ST_SAVE_MSR: stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobes.capture = (state == ST_IDLE) && trapReq;
    strobes.savePc  = (state == ST_SAVE_PC);
    strobes.saveMsr = (state == ST_SAVE_MSR);
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/excEntryData.sv
module excEntryData
  import excEntryPkg::*;
#(
  parameter int SPR_NUM_W = 10,
  parameter int SRR0_NUM  = 26,
  parameter int SRR1_NUM  = 27
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  entryStrobes_t        strobes,
  input  logic [XLEN-1:0]      nextPc,
  input  logic [XLEN-1:0]      msrIn,
  input  logic [XLEN-1:0]      vecAddr,
  output logic                 sprWe,
  output logic [SPR_NUM_W-1:0] sprNum,
  output logic [XLEN-1:0]      sprData,
  output logic                 msrWe,
  output logic [XLEN-1:0]      msrNext,
  output logic                 redirect,
  output logic [XLEN-1:0]      redirectPc
);
  localparam logic [XLEN-1:0] FORCE_ONE  = setMask();
  localparam logic [XLEN-1:0] FORCE_ZERO = clearMask();
  localparam logic [SPR_NUM_W-1:0] NUM0 = SPR_NUM_W'(SRR0_NUM);
  localparam logic [SPR_NUM_W-1:0] NUM1 = SPR_NUM_W'(SRR1_NUM);

  logic [XLEN-1:0] savedPc;
  logic [XLEN-1:0] savedMsr;
  logic [XLEN-1:0] savedVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc  <= '0;
      savedMsr <= '0;
      savedVec <= '0;
    end else if (strobes.capture) begin
      savedPc  <= nextPc;
      savedMsr <= msrIn;
      savedVec <= vecAddr;
    end
  end

  always_comb begin
    sprWe   = strobes.savePc | strobes.saveMsr;
    sprNum  = strobes.saveMsr ? NUM1 : NUM0;
    sprData = strobes.saveMsr ? savedMsr : savedPc;
  end

  assign msrWe      = strobes.saveMsr;
  assign msrNext    = (savedMsr & ~FORCE_ZERO) | FORCE_ONE;
  assign redirect   = strobes.saveMsr;
  assign redirectPc = savedVec;
endmodule

// File: rtl/excEntrySeq.sv
module excEntrySeq
  import excEntryPkg::*;
#(
  parameter int SPR_NUM_W = 10,
  parameter int SRR0_NUM  = 26,
  parameter int SRR1_NUM  = 27
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 trapReq,
  input  logic [63:0]          nextPc,
  input  logic [63:0]          msrIn,
  input  logic [63:0]          vecAddr,
  output logic                 busy,
  output logic                 sprWe,
  output logic [SPR_NUM_W-1:0] sprNum,
  output logic [63:0]          sprData,
  output logic                 msrWe,
  output logic [63:0]          msrNext,
  output logic                 redirect,
  output logic [63:0]          redirectPc
);
  entryStrobes_t strobes;

  excEntryCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .trapReq (trapReq),
    .strobes (strobes),
    .busy    (busy)
  );

  excEntryData #(
    .SPR_NUM_W (SPR_NUM_W),
    .SRR0_NUM  (SRR0_NUM),
    .SRR1_NUM  (SRR1_NUM)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .nextPc     (nextPc),
    .msrIn      (msrIn),
    .vecAddr    (vecAddr),
    .sprWe      (sprWe),
    .sprNum     (sprNum),
    .sprData    (sprData),
    .msrWe      (msrWe),
    .msrNext    (msrNext),
    .redirect   (redirect),
    .redirectPc (redirectPc)
  );
endmodule

// File: rtl/excEntryChk.sv
module excEntryChk #(
  parameter int SPR_NUM_W = 10,
  parameter int SRR0_NUM  = 26,
  parameter int SRR1_NUM  = 27
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 trapReq,
  input logic [63:0]          nextPc,
  input logic [63:0]          msrIn,
  input logic [63:0]          vecAddr,
  input logic                 busy,
  input logic                 sprWe,
  input logic [SPR_NUM_W-1:0] sprNum,
  input logic [63:0]          sprData,
  input logic                 msrWe,
  input logic [63:0]          msrNext,
  input logic                 redirect,
  input logic [63:0]          redirectPc
);
  localparam logic [SPR_NUM_W-1:0] NUM0 = SPR_NUM_W'(SRR0_NUM);
  localparam logic [SPR_NUM_W-1:0] NUM1 = SPR_NUM_W'(SRR1_NUM);
  localparam logic [63:0] KEEP = ~64'h8000_0000_0000_C033;

  AST_ACCEPT_SAVES_PC: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !busy) |=> (sprWe && sprNum == NUM0 && sprData == $past(nextPc))); // R2
  AST_MSR_FOLLOWS_PC: assert property (@(posedge clk) disable iff (!rstN)
    (sprWe && sprNum == NUM0) |=> (sprWe && sprNum == NUM1)); // R3
  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sprWe |-> busy); // R4
  AST_MSR_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    msrWe |-> (msrNext[63] && msrNext[0] && !msrNext[15] && !msrNext[14]
               && !msrNext[5] && !msrNext[4] && !msrNext[1])); // R5
  AST_MSR_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    msrWe |-> ((msrNext & KEEP) == (sprData & KEEP))); // R5
  AST_REDIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect); // R6
  AST_REDIRECT_WITH_SRR1: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> (sprWe && sprNum == NUM1 && msrWe)); // R6
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !busy); // R7
  AST_CAPTURE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (sprWe && sprNum == NUM0) |=> $stable(redirectPc)); // R8
endmodule

bind excEntrySeq excEntryChk #(
  .SPR_NUM_W (SPR_NUM_W),
  .SRR0_NUM  (SRR0_NUM),
  .SRR1_NUM  (SRR1_NUM)
) uChk (.*);

// File: tb/sim_excEntrySeq.sv
`timescale 1ns/1ps
module sim_excEntrySeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic [63:0] nextPc = '0;
  logic [63:0] msrIn = '0;
  logic [63:0] vecAddr = '0;
  logic        busy;
  logic        sprWe;
  logic [9:0]  sprNum;
  logic [63:0] sprData;
  logic        msrWe;
  logic [63:0] msrNext;
  logic        redirect;
  logic [63:0] redirectPc;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  excEntrySeq u0 (.*);

  // behavioural reference: phase 0 idle, 1 SRR0 cycle, 2 SRR1 cycle
  int          mPhase = 0;
  logic [63:0] mPc, mMsr, mVec;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) mPhase <= 0;
    else begin
      cycles <= cycles + 1;
      if (mPhase == 0 && trapReq) begin
        mPhase <= 1; mPc <= nextPc; mMsr <= msrIn; mVec <= vecAddr;
      end else if (mPhase == 1) mPhase <= 2;
      else mPhase <= 0;
    end
  end

  function automatic logic [63:0] expectMsr(logic [63:0] m);
    logic [63:0] r = m;
    r[63] = 1'b1; r[0] = 1'b1;
    r[15] = 1'b0; r[14] = 1'b0; r[5] = 1'b0; r[4] = 1'b0; r[1] = 1'b0;
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R7 busy", 64'(busy), 64'(mPhase != 0));
      check("R4 sprWe", 64'(sprWe), 64'(mPhase != 0));
      check("R5 msrWe", 64'(msrWe), 64'(mPhase == 2));
      check("R6 redirect", 64'(redirect), 64'(mPhase == 2));
      if (mPhase == 1) begin
        check("R2 sprNum", 64'(sprNum), 64'd26);
        check("R2 R8 sprData", sprData, mPc);
      end
      if (mPhase == 2) begin
        check("R3 sprNum", 64'(sprNum), 64'd27);
        check("R3 R8 sprData", sprData, mMsr);
        check("R5 msrNext", msrNext, expectMsr(mMsr));
        check("R6 R8 redirectPc", redirectPc, mVec);
      end
    end
  end

  task automatic drive(logic r, logic [63:0] pc, logic [63:0] m, logic [63:0] v);
    @(negedge clk);
    #1;
    trapReq = r; nextPc = pc; msrIn = m; vecAddr = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 sprWe", 64'(sprWe), 64'd0);
    check("R1 msrWe", 64'(msrWe), 64'd0);
    check("R1 redirect", 64'(redirect), 64'd0);
    rstN = 1'b1;
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    // single entry, all-ones MSR
    drive(1, 64'h0000_0000_0000_1004, 64'hFFFF_FFFF_FFFF_FFFF, 64'h700);
    drive(0, 64'h0, 64'h0, 64'h0);
    drive(0, 64'h0, 64'h0, 64'h0);
    drive(0, 0, 0, 0);
    // all-zero MSR, request held high through busy (R9), inputs change (R8)
    drive(1, 64'hDEAD_BEEF_0000_2000, 64'h0, 64'h500);
    drive(1, 64'h1111, 64'hAAAA_AAAA_AAAA_AAAA, 64'h900);
    drive(1, 64'h2222, 64'h5555_5555_5555_5555, 64'hC00);
    // first idle cycle after redirect: accepted back-to-back (R9)
    drive(1, 64'h3333_0000_0000_0040, 64'h8000_0000_0000_C033, 64'hE00);
    drive(0, 64'h4444, 64'h1234_5678_9ABC_DEF0, 64'hF00);
    drive(0, 0, 0, 0);
    drive(0, 0, 0, 0);
    drive(1, 64'h0123_4567_89AB_CDEF, 64'h1234_5678_9ABC_DEF0, 64'h300);
    drive(0, 0, 0, 0);
    repeat (4) drive(0, 0, 0, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule